// File: doc/BRIEF.md
# Ring-Cascaded FIFO Slice Chain

This block is a first-in/first-out buffer assembled from identical slices. Each slice holds a power-of-two number of 9-bit words. The slices are joined in a ring, so together they act as one FIFO whose depth is the slice depth times the slice count. Every slice sees the same write strobe, read strobe, write data and reset. The right to write and the right to read each sit with exactly one slice at a time, as a token.

When a slice takes a word into its last physical location, it releases its write token. It then signals the next slice in the ring over its expansion output, with a one-cycle pulse and a type bit set to "write". Reading the last physical location hands on the read token in the same way, with the type bit set to "read". A first-load input picks the slice that holds both tokens after reset. Only the slice that holds the read token drives its oldest word. The wrapper ORs the slice data outputs together and combines the per-slice flags into a composite full flag and a composite empty flag. Writes and reads are single-cycle strobes sampled on the rising clock edge. Read data is presented ahead of the read strobe: the oldest word is visible while the FIFO is not empty, and the read strobe pops it.

Top module: `cfifo_chain`

## Requirements
- R1: While reset is low, and in the first cycle after it rises, `empty_o` is 1, `full_o` is 0 and `data_o` is 0. After reset, the slice whose first-load input is low (slice 0) holds both the write token and the read token.
- R2: Words leave in the order they were accepted, including when consecutive words sit in different slices. The chain stores `NUM_SLICES*SLICE_DEPTH` words.
- R3: `full_o` is 1 exactly when `NUM_SLICES*SLICE_DEPTH` words are stored. A write strobe while `full_o` is 1 stores nothing, and the later read sequence does not change.
- R4: `empty_o` is 1 exactly when no word is stored. A read strobe while `empty_o` is 1 removes nothing, and `data_o` stays 0.
- R5: While `empty_o` is 0, `data_o` shows the oldest stored word. While `empty_o` is 1, `data_o` is 0.
- R6: At every cycle, exactly one slice holds the write token and exactly one slice holds the read token.
- R7: An accepted write to a slice's last location raises that slice's expansion pulse for one cycle with the type bit 0, and the next slice in the ring holds the write token in the following cycle. An accepted read of the last location does the same with the type bit 1 and the read token.
- R8: A read strobe and a write strobe in the same cycle are both performed when the FIFO is neither full nor empty. When it is full, only the read is performed. When it is empty, only the write is performed.
- R9: The tokens go around the ring repeatedly under sustained traffic without losing order or capacity.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Write strobe, one word per cycle |
| rd_i | input | 1 | Read strobe, pops the oldest word |
| data_i | input | 9 | Write data |
| data_o | output | 9 | Oldest stored word, or 0 when empty |
| full_o | output | 1 | Composite full flag |
| empty_o | output | 1 | Composite empty flag |

## Verification
A pure fill to capacity followed by a pure drain shows whether the tokens pass at every slice boundary and whether word order holds across the seams. Extra strobes at full and at empty then show whether blocked operations are really discarded, because any stray word would appear in the drained sequence. Simultaneous read and write at full, at empty and in mid-level tell apart the three acceptance cases. Long random runs with a bias that alternates between filling and draining send the tokens around the ring many times, hit both flags repeatedly, and check every popped word against a reference queue.

// File: rtl/cfifo_pkg.sv
package cfifo_pkg;
  localparam int WORD_W = 9;

  // expansion link: one-cycle pulse plus token type (0 write, 1 read)
  typedef struct packed {
    logic vld;
    logic rd;
  } xpass_t;
endpackage

// File: rtl/cfifo_ptr.sv
module cfifo_ptr #(
  parameter int DEPTH = 8,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        adv_i,
  output logic [AW:0] ptr_o,
  output logic        at_last_o
);
  logic [AW:0] ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    ptr_q <= '0;
    else if (adv_i) ptr_q <= ptr_q + 1'b1;
  end

  assign ptr_o     = ptr_q;
  assign at_last_o = (ptr_q[AW-1:0] == AW'(DEPTH - 1));
endmodule

// File: rtl/cfifo_store.sv
module cfifo_store #(
  parameter int DEPTH = 8,
  parameter int W = 9,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [W-1:0]  rdata_o
);
  logic [W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/cfifo_slice.sv
module cfifo_slice
  import cfifo_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int W = WORD_W,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         first_load_ni,
  input  logic         wr_i,
  input  logic         rd_i,
  input  logic [W-1:0] data_i,
  input  xpass_t       xin_i,
  output xpass_t       xout_o,
  output logic [W-1:0] data_o,
  output logic         full_o,
  output logic         empty_o,
  output logic         wr_own_o,
  output logic         rd_own_o
);
  logic [AW:0]  wptr, rptr;
  logic         w_last, r_last;
  logic         wr_go, rd_go;
  logic         wr_own_q, rd_own_q;
  logic [W-1:0] rdata;

  assign empty_o = (wptr == rptr);
  assign full_o  = (wptr[AW] != rptr[AW]) && (wptr[AW-1:0] == rptr[AW-1:0]);

  assign wr_go = wr_i & wr_own_q & ~full_o;
  assign rd_go = rd_i & rd_own_q & ~empty_o;

  cfifo_ptr #(.DEPTH(DEPTH)) u_wptr (
    .clk_i, .rst_ni, .adv_i(wr_go), .ptr_o(wptr), .at_last_o(w_last)
  );

  cfifo_ptr #(.DEPTH(DEPTH)) u_rptr (
    .clk_i, .rst_ni, .adv_i(rd_go), .ptr_o(rptr), .at_last_o(r_last)
  );

  cfifo_store #(.DEPTH(DEPTH), .W(W)) u_mem (
    .clk_i,
    .we_i   (wr_go),
    .waddr_i(wptr[AW-1:0]),
    .wdata_i(data_i),
    .raddr_i(rptr[AW-1:0]),
    .rdata_o(rdata)
  );

  // a write pass and a read pass cannot coincide: reading the last slot
  // while writing it implies full, which blocks the write
  always_comb begin
    xout_o.vld = (wr_go & w_last) | (rd_go & r_last);
    xout_o.rd  = rd_go & r_last;
  end

  // incoming pass has priority so a one-slice ring keeps its own tokens
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_own_q <= ~first_load_ni;
      rd_own_q <= ~first_load_ni;
    end else begin
      if (xin_i.vld && !xin_i.rd)   wr_own_q <= 1'b1;
      else if (wr_go && w_last)     wr_own_q <= 1'b0;
      if (xin_i.vld && xin_i.rd)    rd_own_q <= 1'b1;
      else if (rd_go && r_last)     rd_own_q <= 1'b0;
    end
  end

  assign wr_own_o = wr_own_q;
  assign rd_own_o = rd_own_q;
  assign data_o   = (rd_own_q && !empty_o) ? rdata : '0;
endmodule

// File: rtl/cfifo_chain.sv
module cfifo_chain
  import cfifo_pkg::*;
#(
  parameter int NUM_SLICES  = 3,
  parameter int SLICE_DEPTH = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [WORD_W-1:0] data_i,
  output logic [WORD_W-1:0] data_o,
  output logic              full_o,
  output logic              empty_o
);
  xpass_t            xout [NUM_SLICES];
  logic [WORD_W-1:0] sdata [NUM_SLICES];
  logic [NUM_SLICES-1:0] s_full, s_empty;
  logic [NUM_SLICES-1:0] wr_own, rd_own;
  logic [NUM_SLICES-1:0] pass_vld, pass_rd;

  for (genvar i = 0; i < NUM_SLICES; i++) begin : g_slice
    localparam int PREV = (i == 0) ? NUM_SLICES - 1 : i - 1;

    cfifo_slice #(.DEPTH(SLICE_DEPTH), .W(WORD_W)) u_slice (
      .clk_i,
      .rst_ni,
      .first_load_ni((i == 0) ? 1'b0 : 1'b1),
      .wr_i,
      .rd_i,
      .data_i,
      .xin_i   (xout[PREV]),
      .xout_o  (xout[i]),
      .data_o  (sdata[i]),
      .full_o  (s_full[i]),
      .empty_o (s_empty[i]),
      .wr_own_o(wr_own[i]),
      .rd_own_o(rd_own[i])
    );

    assign pass_vld[i] = xout[i].vld;
    assign pass_rd[i]  = xout[i].rd;
  end

  always_comb begin
    data_o = '0;
    for (int i = 0; i < NUM_SLICES; i++) data_o |= sdata[i];
  end

  assign full_o  = &s_full;
  assign empty_o = &s_empty;
endmodule

// File: rtl/cfifo_chain_chk.sv
module cfifo_chain_chk #(
  parameter int NUM_SLICES = 3
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  wr_i,
  input logic                  rd_i,
  input logic [8:0]            data_o,
  input logic                  full_o,
  input logic                  empty_o,
  input logic [NUM_SLICES-1:0] wr_own,
  input logic [NUM_SLICES-1:0] rd_own,
  input logic [NUM_SLICES-1:0] pass_vld,
  input logic [NUM_SLICES-1:0] pass_rd
);
  // R6
  wr_token_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(wr_own) == 1);
  // R6
  rd_token_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(rd_own) == 1);
  // R3
  full_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o && !rd_i |=> full_o);
  // R4
  empty_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_o && !wr_i |=> empty_o);
  // R5
  empty_data_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_o |-> data_o == '0);
  // R3
  flags_exclusive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(full_o && empty_o));

  for (genvar i = 0; i < NUM_SLICES; i++) begin : g_pass
    localparam int NXT = (i == NUM_SLICES - 1) ? 0 : i + 1;
    // R7
    wr_pass_hand_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pass_vld[i] && !pass_rd[i] |=> wr_own[NXT]);
    // R7
    rd_pass_hand_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pass_vld[i] && pass_rd[i] |=> rd_own[NXT]);
    // R7
    wr_pass_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pass_vld[i] && !pass_rd[i] |=> !(pass_vld[i] && !pass_rd[i]));
    // R7
    pass_type_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pass_rd[i] |-> pass_vld[i]);
  end
endmodule

bind cfifo_chain cfifo_chain_chk #(.NUM_SLICES(NUM_SLICES)) u_chk (.*);

// File: tb/tb_cfifo_chain.sv
module tb_cfifo_chain;
  localparam int NS  = 3;
  localparam int SD  = 8;
  localparam int CAP = NS * SD;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr = 1'b0, rd = 1'b0;
  logic [8:0] din = '0;
  logic [8:0] dout;
  logic       full, empty;

  int n_chk = 0;
  int n_bad = 0;
  logic [8:0] q[$];

  always #4 clk = ~clk;

  cfifo_chain #(.NUM_SLICES(NS), .SLICE_DEPTH(SD)) dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .rd_i(rd),
    .data_i(din), .data_o(dout), .full_o(full), .empty_o(empty)
  );

  function automatic logic [8:0] exp_data();
    return (q.size() > 0) ? q[0] : 9'd0;
  endfunction

  task automatic cmp(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic check_outs(string req);
    cmp(req, "empty", int'(empty), int'(q.size() == 0));
    cmp(req, "full",  int'(full),  int'(q.size() == CAP));
    cmp(req, "data",  int'(dout),  int'(exp_data()));
  endtask

  // called at negedge: check, drive, update model, advance one cycle
  task automatic step(string req, logic w, logic r, logic [8:0] d);
    bit w_ok, r_ok;
    check_outs(req);
    wr = w; rd = r; din = d;
    w_ok = w && (q.size() < CAP);
    r_ok = r && (q.size() > 0);
    if (r_ok) void'(q.pop_front());
    if (w_ok) q.push_back(d);
    @(posedge clk);
    @(negedge clk);
    wr = 1'b0; rd = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check_outs("R1");
    rst_n = 1'b1;
    @(negedge clk);
    check_outs("R1");

    // fill to capacity across both slice seams
    for (int i = 0; i < CAP; i++) step("R2", 1'b1, 1'b0, 9'(i + 1));
    cmp("R3", "full after capacity", int'(full), 1);
    // writes while full must be discarded
    for (int i = 0; i < 5; i++) step("R3", 1'b1, 1'b0, 9'(400 + i));
    // drain, order across slice boundaries (R7 hand-offs)
    for (int i = 0; i < CAP; i++) step("R7", 1'b0, 1'b1, '0);
    cmp("R4", "empty after drain", int'(empty), 1);
    // reads while empty must be discarded
    for (int i = 0; i < 4; i++) step("R4", 1'b0, 1'b1, '0);
    cmp("R5", "data while empty", int'(dout), 0);

    // simultaneous read and write at empty, mid-level, full
    step("R8", 1'b1, 1'b1, 9'd77);
    for (int i = 0; i < 10; i++) step("R8", 1'b1, 1'b0, 9'(100 + i));
    for (int i = 0; i < 6; i++) step("R8", 1'b1, 1'b1, 9'(200 + i));
    while (q.size() < CAP) step("R8", 1'b1, 1'b0, 9'(300 + q.size()));
    step("R8", 1'b1, 1'b1, 9'd511);
    cmp("R8", "level after r+w at full", int'(full), 0);
    while (q.size() > 0) step("R5", 1'b0, 1'b1, '0);

    // random traffic with alternating bias, many ring laps
    for (int blk = 0; blk < 40; blk++) begin
      int pw = (blk % 2 == 0) ? 70 : 30;
      for (int c = 0; c < 150; c++) begin
        logic w = ($urandom_range(99) < pw);
        logic r = ($urandom_range(99) < (100 - pw));
        step("R9", w, r, 9'($urandom_range(511)));
      end
    end

    // reset in mid-traffic
    for (int i = 0; i < 7; i++) step("R1", 1'b1, 1'b0, 9'(i + 50));
    rst_n = 1'b0;
    q.delete();
    @(negedge clk);
    check_outs("R1");
    rst_n = 1'b1;
    @(negedge clk);
    check_outs("R1");
    for (int i = 0; i < 3; i++) step("R1", 1'b1, 1'b0, 9'(i + 9));
    while (q.size() > 0) step("R2", 1'b0, 1'b1, '0);
    check_outs("R4");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule